// File: doc/BRIEF.md
# External Interrupt Line Controller

This block gathers a parameterised number of external interrupt lines and combines them into one interrupt request for a processor. Every line has three settings held in registers: a mask, a sensitivity (edge or level) and a polarity (low/falling or high/rising). Software reads each setting from its own word and changes it through two write-only aliases. A write of ones to the set alias turns the chosen bits on. A write of ones to the clear alias turns them off. Zero bits leave their lines untouched.

Each input passes through a synchronizer before event detection. An event latches a pending bit. Software clears pending bits by writing ones to an acknowledge word. A per-line routing enable decides whether a line may reach the processor at all. The output is high while any line is pending, unmasked and routed. Lines are packed 32 to a 32-bit word. The word for line n is at group base + (n/32)*4, at bit n mod 32.

Top module: `eintc_ctrl`

## Requirements
- R1: After reset, every implemented line reads back as masked (mask bit 1), edge-sensitive (sensitivity bit 0), active-low (polarity bit 0), not pending and not routed (routing bit 0), and `irq_out` is low.
- R2: Line n lives in word base + (n/32)*4 at bit n mod 32. Bits above the last line read 0. Read data appears on `rdata` on the clock edge at which `rd_en` is sampled.
- R3: Ones written to mask-set (0x0C0) mask those lines, ones written to mask-clear (0x100) unmask them, and zero bits change nothing. The mask word at 0x080 reads 1 for each masked line.
- R4: Sensitivity reads at 0x140, with set alias 0x180 and clear alias 0x1C0; 1 means level. Polarity reads at 0x300, with set alias 0x340 and clear alias 0x380; 1 means high/rising.
- R5: In edge mode a line becomes pending on its selected edge of the synchronized input, by the third clock edge after the input changes. The opposite edge leaves it idle.
- R6: In level mode the pending bit is set while the active level is present. An acknowledge during the active level has no effect. The bit stays set after the level goes away until it is acknowledged.
- R7: Ones written to the acknowledge word (0x040) clear the matching pending bits, and zero bits leave them. An acknowledge in the same cycle as a new event leaves the bit pending.
- R8: `irq_out` is high exactly when some line is pending, unmasked and routed. The status word (0x000) shows pending bits whatever the mask.
- R9: The routing-enable words at 0x400 are read/write. A line whose routing bit is 0 never raises `irq_out`.
- R10: Writes to the status word have no effect on the pending bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_LINES | Asynchronous external interrupt inputs |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with 40 lines, which gives one full word and one partial word. That makes the padding bits of the second word and the word-offset arithmetic visible at the register interface. With so few lines, every line can be swept through all four combinations of sensitivity and polarity. For each combination the bench checks read-back, detection, stickiness, the interrupt output and acknowledge. Directed cases then cover the opposite edge, acknowledge during an active level, acknowledge in the same cycle as a new edge, masked pending lines, routing and writes to status.

// File: rtl/eintc_pkg.sv
package eintc_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned GRP_LSB = 6;
   localparam int unsigned GRP_W = 5;
   localparam int unsigned MAX_WORDS = 16;

   // register group selected by address bits [10:6]
   typedef enum logic [GRP_W-1:0] {
      GRP_STAT = 5'h00,
      GRP_ACK  = 5'h01,
      GRP_MASK = 5'h02,
      GRP_MSET = 5'h03,
      GRP_MCLR = 5'h04,
      GRP_SENS = 5'h05,
      GRP_SSET = 5'h06,
      GRP_SCLR = 5'h07,
      GRP_POL  = 5'h0C,
      GRP_PSET = 5'h0D,
      GRP_PCLR = 5'h0E,
      GRP_ROUT = 5'h10
   } grp_e;
endpackage

// File: rtl/eintc_sync.sv
module eintc_sync #(
   parameter int unsigned N      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("eintc_sync needs at least two stages");
   end

   logic [N-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/eintc_bitreg.sv
module eintc_bitreg #(
   parameter int unsigned N        = 8,
   parameter bit          RST_ONES = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_ONES ? {N{1'b1}} : {N{1'b0}};
      else        q <= (q | set_i) & ~clr_i;   // clear dominates
   end
endmodule

// File: rtl/eintc_detect.sv
module eintc_detect #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] sens,
   input  logic [N-1:0] pol,
   input  logic [N-1:0] ack,
   output logic [N-1:0] pend
);
   logic [N-1:0] prev;
   logic [N-1:0] rise, fall, edge_hit, lvl_hit, evt;

   always_comb begin
      rise     = lvl & ~prev;
      fall     = ~lvl & prev;
      edge_hit = (pol & rise) | (~pol & fall);
      lvl_hit  = ~(lvl ^ pol);
      evt      = (sens & lvl_hit) | (~sens & edge_hit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= '0;
         pend <= '0;
      end else begin
         prev <= lvl;
         pend <= (pend & ~ack) | evt;   // a new event beats ack
      end
   end
endmodule

// File: rtl/eintc_ctrl.sv
module eintc_ctrl
   import eintc_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 64,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_in,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [WORD_W-1:0]    wdata,
   output logic [WORD_W-1:0]    rdata,
   output logic                 irq_out
);
   localparam int unsigned NW = (NUM_LINES + WORD_W - 1) / WORD_W;
   localparam int unsigned NB = NW * WORD_W;

   if (NUM_LINES < 1 || NW > MAX_WORDS) begin : g_bad_lines
      $error("NUM_LINES must be within 1..512");
   end
   if (ADDR_W < 11) begin : g_bad_addr
      $error("ADDR_W must be at least 11");
   end

   // address decode
   logic [GRP_W-1:0] grp;
   logic [3:0]       widx;
   logic             addr_ok;

   assign grp     = addr[GRP_LSB +: GRP_W];
   assign widx    = addr[5:2];
   assign addr_ok = ((addr >> 11) == '0) && (addr[1:0] == 2'b00) && (32'(widx) < NW);

   // write data spread over the line vector
   logic [NUM_LINES-1:0] wbits, wsel;
   for (genvar n = 0; n < NUM_LINES; n++) begin : g_spread
      assign wsel[n]  = (widx == 4'(n / WORD_W));
      assign wbits[n] = wsel[n] & wdata[n % WORD_W];
   end

   function automatic logic hit(input logic we, input logic ok,
                                input logic [GRP_W-1:0] g, input grp_e want);
      return we && ok && (g == want);
   endfunction

   logic [NUM_LINES-1:0] mask_set, mask_clr, sens_set, sens_clr;
   logic [NUM_LINES-1:0] pol_set, pol_clr, rout_set, rout_clr, ack_bits;

   always_comb begin
      mask_set = hit(wr_en, addr_ok, grp, GRP_MSET) ? wbits : '0;
      mask_clr = hit(wr_en, addr_ok, grp, GRP_MCLR) ? wbits : '0;
      sens_set = hit(wr_en, addr_ok, grp, GRP_SSET) ? wbits : '0;
      sens_clr = hit(wr_en, addr_ok, grp, GRP_SCLR) ? wbits : '0;
      pol_set  = hit(wr_en, addr_ok, grp, GRP_PSET) ? wbits : '0;
      pol_clr  = hit(wr_en, addr_ok, grp, GRP_PCLR) ? wbits : '0;
      rout_set = hit(wr_en, addr_ok, grp, GRP_ROUT) ? wbits : '0;
      rout_clr = hit(wr_en, addr_ok, grp, GRP_ROUT) ? (wsel & ~wbits) : '0;
      ack_bits = hit(wr_en, addr_ok, grp, GRP_ACK)  ? wbits : '0;
   end

   // per-line settings
   logic [NUM_LINES-1:0] mask_q, sens_q, pol_q, rout_q, pend_q, lvl_s;

   eintc_bitreg #(.N(NUM_LINES), .RST_ONES(1'b1)) i_mask (
      .clk(clk), .rst_n(rst_n), .set_i(mask_set), .clr_i(mask_clr), .q(mask_q));
   eintc_bitreg #(.N(NUM_LINES), .RST_ONES(1'b0)) i_sens (
      .clk(clk), .rst_n(rst_n), .set_i(sens_set), .clr_i(sens_clr), .q(sens_q));
   eintc_bitreg #(.N(NUM_LINES), .RST_ONES(1'b0)) i_pol (
      .clk(clk), .rst_n(rst_n), .set_i(pol_set), .clr_i(pol_clr), .q(pol_q));
   eintc_bitreg #(.N(NUM_LINES), .RST_ONES(1'b0)) i_rout (
      .clk(clk), .rst_n(rst_n), .set_i(rout_set), .clr_i(rout_clr), .q(rout_q));

   eintc_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .din(line_in), .dout(lvl_s));

   eintc_detect #(.N(NUM_LINES)) i_detect (
      .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .sens(sens_q), .pol(pol_q),
      .ack(ack_bits), .pend(pend_q));

   assign irq_out = |(pend_q & ~mask_q & rout_q);

   // read path
   logic [NB-1:0]     sel_wide;
   logic [WORD_W-1:0] rd_word;

   always_comb begin
      sel_wide = '0;
      case (grp)
         GRP_STAT: sel_wide[NUM_LINES-1:0] = pend_q;
         GRP_MASK: sel_wide[NUM_LINES-1:0] = mask_q;
         GRP_SENS: sel_wide[NUM_LINES-1:0] = sens_q;
         GRP_POL:  sel_wide[NUM_LINES-1:0] = pol_q;
         GRP_ROUT: sel_wide[NUM_LINES-1:0] = rout_q;
         default:  sel_wide = '0;
      endcase
      rd_word = '0;
      for (int w = 0; w < NW; w++) begin
         if (widx == 4'(w)) rd_word = sel_wide[w*WORD_W +: WORD_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= addr_ok ? rd_word : '0;
   end
endmodule

// File: rtl/eintc_chk.sv
module eintc_chk #(
   parameter int unsigned NUM_LINES = 64,
   parameter int unsigned ADDR_W    = 12
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic [ADDR_W-1:0]    addr,
   input logic                 wdata_b0,
   input logic                 irq_out,
   input logic [NUM_LINES-1:0] pend,
   input logic [NUM_LINES-1:0] mask,
   input logic [NUM_LINES-1:0] rout
);
   // R9: no routed line, no request
   a_r9_unrouted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rout == '0) |-> !irq_out);

   // R8: all lines masked, no request
   a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask) |-> !irq_out);

   // R7: pending bits only drop after an acknowledge write
   a_r7_clear_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(pend) & ~pend)) |-> $past(wr_en && addr[10:6] == 5'h01));

   // R3: mask-set write of bit 0 masks line 0
   a_r3_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(12'h0C0) && wdata_b0) |=> mask[0]);

   // R3: mask-clear write of bit 0 unmasks line 0
   a_r3_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(12'h100) && wdata_b0) |=> !mask[0]);
endmodule

bind eintc_ctrl eintc_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata_b0(wdata[0]),
   .irq_out(irq_out), .pend(pend_q), .mask(mask_q), .rout(rout_q));

// File: tb/test_eintc_ctrl.sv
module test_eintc_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 40;
   localparam int AW = 12;

   localparam logic [AW-1:0] A_STAT = 12'h000, A_ACK = 12'h040, A_MASK = 12'h080,
      A_MSET = 12'h0C0, A_MCLR = 12'h100, A_SENS = 12'h140, A_SSET = 12'h180,
      A_SCLR = 12'h1C0, A_POL = 12'h300, A_PSET = 12'h340, A_PCLR = 12'h380,
      A_ROUT = 12'h400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NL-1:0] line_in = '1;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic irq_out;
   int total = 0, bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eintc_ctrl #(.NUM_LINES(NL), .ADDR_W(AW)) i_eintc_ctrl (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out));

   function automatic logic [AW-1:0] wa(input logic [AW-1:0] base, input int n);
      return base + AW'((n / 32) * 4);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0; d = rdata;
   endtask

   task automatic idle(input int c);
      repeat (c) @(negedge clk);
   endtask

   task automatic rchk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(req, d, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] b;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      idle(5);

      // R1 / R2: reset state and padding of partial word
      rchk("R1 status w0", A_STAT, 32'h0);
      rchk("R1 status w1", A_STAT + 4, 32'h0);
      rchk("R1 mask w0", A_MASK, 32'hFFFF_FFFF);
      rchk("R2 mask w1 padding", A_MASK + 4, 32'h0000_00FF);
      rchk("R1 sens w1", A_SENS + 4, 32'h0);
      rchk("R1 pol w0", A_POL, 32'h0);
      rchk("R1 rout w0", A_ROUT, 32'h0);
      check("R1 irq", {31'b0, irq_out}, 32'h0);

      // R9: routing words read/write
      wr(A_ROUT, 32'hFFFF_FFFF);
      wr(A_ROUT + 4, 32'hFFFF_FFFF);
      rchk("R9 rout w1", A_ROUT + 4, 32'h0000_00FF);

      // R3: aliases, zero bits untouched
      wr(A_MCLR, 32'h0000_00F0);
      rchk("R3 mask after clr", A_MASK, 32'hFFFF_FF0F);
      wr(A_MSET, 32'h0000_0010);
      rchk("R3 mask after set", A_MASK, 32'hFFFF_FF1F);
      wr(A_MSET, 32'hFFFF_FFFF);

      // sweep every line through all sensitivity/polarity combinations
      for (int n = 0; n < NL; n++) begin
         for (int m = 0; m < 4; m++) begin
            logic s, p;
            s = m[1]; p = m[0];
            b = 32'(1) << (n % 32);
            wr(wa(s ? A_SSET : A_SCLR, n), b);
            wr(wa(p ? A_PSET : A_PCLR, n), b);
            rchk("R4 sens readback", wa(A_SENS, n), s ? b : 32'h0);
            rchk("R4 pol readback", wa(A_POL, n), p ? b : 32'h0);
            line_in[n] = ~p;
            idle(5);
            wr(wa(A_ACK, n), 32'hFFFF_FFFF);
            rchk(s ? "R6 idle" : "R5 idle", wa(A_STAT, n), 32'h0);
            wr(wa(A_MCLR, n), b);
            line_in[n] = p;
            idle(5);
            rchk(s ? "R6 level pending" : "R5 edge pending", wa(A_STAT, n), b);
            check("R8 irq raised", {31'b0, irq_out}, 32'h1);
            line_in[n] = ~p;
            idle(5);
            rchk(s ? "R6 sticky" : "R5 sticky", wa(A_STAT, n), b);
            wr(wa(A_ACK, n), b);
            rchk("R7 ack clears", wa(A_STAT, n), 32'h0);
            check("R8 irq dropped", {31'b0, irq_out}, 32'h0);
            wr(wa(A_MSET, n), b);
            wr(wa(A_SCLR, n), b);
            wr(wa(A_PCLR, n), b);
            line_in[n] = 1'b1;
            idle(5);
            wr(wa(A_ACK, n), 32'hFFFF_FFFF);
         end
      end

      // R5: opposite edge ignored (line 2 set to rising)
      wr(A_PSET, 32'h4);
      line_in[2] = 1'b0;
      idle(5);
      rchk("R5 falling ignored in rising mode", A_STAT, 32'h0);
      line_in[2] = 1'b1;
      idle(5);
      rchk("R5 rising taken", A_STAT, 32'h4);
      wr(A_PCLR, 32'h4);
      wr(A_ACK, 32'h4);

      // R6: ack while level active has no effect (line 3 active-low level)
      wr(A_SSET, 32'h8);
      line_in[3] = 1'b0;
      idle(5);
      wr(A_ACK, 32'h8);
      rchk("R6 ack during active level", A_STAT, 32'h8);
      line_in[3] = 1'b1;
      idle(5);
      rchk("R6 held after level gone", A_STAT, 32'h8);
      wr(A_ACK, 32'h8);
      rchk("R6 ack after level gone", A_STAT, 32'h0);
      wr(A_SCLR, 32'h8);

      // R7: zeros in ack leave bits; ack in event cycle leaves bit pending
      line_in[6] = 1'b0;
      idle(5);
      line_in[5] = 1'b0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      wr_en = 1'b1; addr = A_ACK; wdata = 32'h20;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
      rchk("R7 ack same cycle as edge", A_STAT, 32'h60);
      wr(A_ACK, 32'h20);
      rchk("R7 zero bits keep pending", A_STAT, 32'h40);
      wr(A_ACK, 32'h40);
      line_in[5] = 1'b1; line_in[6] = 1'b1;
      idle(5);

      // R8 / R9 / R10: masked pending, routing and status writes
      line_in[7] = 1'b0;
      idle(5);
      rchk("R8 masked line still in status", A_STAT, 32'h80);
      check("R8 masked no irq", {31'b0, irq_out}, 32'h0);
      wr(A_STAT, 32'h0);
      rchk("R10 status write zeros ignored", A_STAT, 32'h80);
      wr(A_STAT, 32'hFFFF_FFFF);
      rchk("R10 status write ones ignored", A_STAT, 32'h80);
      wr(A_MCLR, 32'h80);
      check("R8 unmasked irq", {31'b0, irq_out}, 32'h1);
      wr(A_ROUT, 32'h0);
      check("R9 unrouted no irq", {31'b0, irq_out}, 32'h0);
      rchk("R9 rout readback", A_ROUT, 32'h0);
      wr(A_ROUT, 32'hFFFF_FFFF);
      check("R9 rerouted irq", {31'b0, irq_out}, 32'h1);
      wr(A_ACK, 32'h80);
      check("R7 irq after ack", {31'b0, irq_out}, 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule